// File: doc/BRIEF.md
# SPI Slave Word Receiver

This block is the receive side of a write-only SPI slave control port. It runs on a fast system clock and oversamples the serial clock, chip select and data input through a short synchronizer chain. Edges of the serial clock are found in the system clock domain. A transaction starts when chip select goes low. The first byte must name this slave and request a write. After that, the block packs each group of data bytes into one wide word and passes it downstream through a valid/ready handshake.

A status output tells the master whether another word can be taken. The status drops as soon as a word is complete. It returns high once the downstream consumer has accepted that word, and the master polls it between words. A transaction that names another address or asks for a read is ignored until chip select rises. A write that ends part way through a word loses the partial word and produces a one-cycle error pulse.

Top module: `spi_word_rx`

## Requirements
- R1: After reset, `spi_rdy` is 1, and `out_valid` and `rx_err` are 0.
- R2: Serial data is sampled on each rising serial clock edge, most significant bit first. A byte is taken on the falling edge that follows its eighth rising edge. The first byte of a transaction is accepted only when it equals 0x80: address 1000000b in bits 7:1 and a write flag of 0 in bit 0.
- R3: In an accepted transaction, each group of 4 data bytes forms one 32-bit word. The first byte received becomes bits 31:24. The word appears on `out_data` with `out_valid` high within a few system clocks of the last byte's final falling edge.
- R4: If the first byte is anything other than 0x80 (another address, or bit 0 set for a read), the block ignores every later byte of that transaction. In that case `out_valid` stays 0 and `rx_err` does not pulse, even if chip select rises mid-word.
- R5: While `out_valid` is high, `spi_rdy` is 0, and `out_data` holds steady until a cycle with `out_ready` high. After that accepting cycle, `out_valid` falls and `spi_rdy` returns to 1.
- R6: One transaction can carry several words back to back. Each word is delivered in order.
- R7: If chip select rises during an accepted write while a word is partly received (at least one data bit but fewer than 4 full bytes), the partial word is discarded and `rx_err` pulses once. A rise on a word boundary produces no pulse.
- R8: If a word completes while the previous word is still waiting for `out_ready`, the new word is discarded and `rx_err` pulses once. The held word is left unchanged.
- R9: Bit, byte and state counters return to their start values whenever chip select is high. The transaction after an aborted one therefore decodes correctly from its first bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_rdy | output | 1 | High when another word can be taken |
| out_valid | output | 1 | A received word is waiting on out_data |
| out_ready | input | 1 | Consumer accepts the word this cycle |
| out_data | output | 32 | Received word |
| rx_err | output | 1 | One-cycle pulse on a lost word |

## Verification
A table of first bytes and data words is tried. It includes 0x80 with words whose set bits sit at the top, at the bottom and across all positions, which separates correct bit order and byte order from reversed or shifted assembly. It also includes wrong addresses, a read flag and a top-bit-only header, which show whether the header compare checks every bit. Directed sequences then cover back-to-back words with polling, aborts after whole bytes, after a few bits and exactly on a word boundary, an abort inside an ignored transaction, and an overrun while a word is held. Together these tell real discard and error logic apart from logic that merely never asserts its outputs.

// File: rtl/spi_word_rx_pkg.sv
package spi_word_rx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_DATA = 2'd2,
      ST_SKIP = 2'd3
   } rx_state_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] chain [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_pin_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_active,
   input  logic              sclk_rise,
   input  logic              sclk_fall,
   input  logic              mosi,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_data,
   output logic              mid_byte
);
   localparam int CW = $clog2(BYTE_W + 1);
   localparam logic [CW-1:0] FULL = CW'(BYTE_W);

   logic [CW-1:0]     bit_cnt;
   logic [BYTE_W-1:0] shreg;

   if (BYTE_W < 2) begin : g_bad_width
      $error("spi_bit_shifter: BYTE_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt   <= '0;
         shreg     <= '0;
         byte_vld  <= 1'b0;
         byte_data <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (!cs_active) begin
            bit_cnt <= '0;
         end else if (sclk_rise && bit_cnt != FULL) begin
            shreg   <= {shreg[BYTE_W-2:0], mosi};
            bit_cnt <= bit_cnt + 1'b1;
         end else if (sclk_fall && bit_cnt == FULL) begin
            byte_vld  <= 1'b1;
            byte_data <= shreg;
            bit_cnt   <= '0;
         end
      end
   end

   assign mid_byte = (bit_cnt != '0);

   a_r9_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_active |=> bit_cnt == '0);
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= FULL);
   a_r2_byte_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |-> $past(sclk_fall) && $past(cs_active));
endmodule

// File: rtl/spi_word_rx.sv
module spi_word_rx #(
   parameter int                 WORD_BYTES  = 4,
   parameter int                 BYTE_W      = 8,
   parameter int                 SYNC_STAGES = 2,
   parameter logic [BYTE_W-2:0]  DEV_ADDR    = 7'h40
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         spi_sclk,
   input  logic                         spi_cs_n,
   input  logic                         spi_mosi,
   output logic                         spi_rdy,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic [WORD_BYTES*BYTE_W-1:0] out_data,
   output logic                         rx_err
);
   import spi_word_rx_pkg::*;

   localparam int WORD_W = WORD_BYTES * BYTE_W;
   localparam int IDX_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(WORD_BYTES - 1);
   localparam logic [BYTE_W-1:0] HDR_CODE = {DEV_ADDR, 1'b0};

   if (WORD_BYTES < 1) begin : g_bad_words
      $error("spi_word_rx: WORD_BYTES must be at least 1");
   end

   // pin synchronizer: bit 2 cs_n, bit 1 sclk, bit 0 mosi
   logic [2:0] pins_s;
   spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({spi_cs_n, spi_sclk, spi_mosi}),
      .dout (pins_s)
   );

   logic cs_n_prev, sclk_prev;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n_prev <= 1'b1;
         sclk_prev <= 1'b0;
      end else begin
         cs_n_prev <= pins_s[2];
         sclk_prev <= pins_s[1];
      end
   end

   logic cs_begin, cs_end, sclk_rise, sclk_fall;
   assign cs_begin  = !pins_s[2] &&  cs_n_prev;
   assign cs_end    =  pins_s[2] && !cs_n_prev;
   assign sclk_rise =  pins_s[1] && !sclk_prev;
   assign sclk_fall = !pins_s[1] &&  sclk_prev;

   logic              byte_vld, mid_byte;
   logic [BYTE_W-1:0] byte_data;
   spi_bit_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_active(!pins_s[2]),
      .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall),
      .mosi     (pins_s[0]),
      .byte_vld (byte_vld),
      .byte_data(byte_data),
      .mid_byte (mid_byte)
   );

   rx_state_e         state;
   logic [WORD_W-1:0] acc, acc_next;
   logic [IDX_W-1:0]  idx;

   if (WORD_BYTES == 1) begin : g_single
      assign acc_next = byte_data;
   end else begin : g_multi
      assign acc_next = {acc[WORD_W-BYTE_W-1:0], byte_data};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         acc       <= '0;
         idx       <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         rx_err    <= 1'b0;
      end else begin
         rx_err <= 1'b0;
         if (out_valid && out_ready) out_valid <= 1'b0;
         if (cs_end) begin
            if (state == ST_DATA && (idx != '0 || mid_byte)) rx_err <= 1'b1;
            state <= ST_IDLE;
            idx   <= '0;
         end else begin
            case (state)
               ST_IDLE: if (cs_begin) state <= ST_HDR;
               ST_HDR:  if (byte_vld) state <= (byte_data == HDR_CODE) ? ST_DATA : ST_SKIP;
               ST_DATA: if (byte_vld) begin
                  acc <= acc_next;
                  if (idx == LAST_IDX) begin
                     idx <= '0;
                     if (out_valid && !out_ready) begin
                        rx_err <= 1'b1;
                     end else begin
                        out_valid <= 1'b1;
                        out_data  <= acc_next;
                     end
                  end else begin
                     idx <= idx + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign spi_rdy = !out_valid;

   a_r5_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));
   a_r3_valid_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(byte_vld) && $past(state == ST_DATA));
   a_r4_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_SKIP && !out_valid |=> !out_valid && !rx_err);
   a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      rx_err |-> $past(cs_end) || $past(byte_vld));
   a_r9_idle_on_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      cs_end |=> state == ST_IDLE && idx == '0);
endmodule

// File: tb/spi_word_rx_tb.sv
module spi_word_rx_tb;
   localparam int H = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, out_ready = 1'b0;
   logic        spi_rdy, out_valid, rx_err;
   logic [31:0] out_data;
   int          total = 0, bad = 0, err_cnt = 0;

   always #4 clk = ~clk;

   spi_word_rx u_dut (
      .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
      .spi_rdy(spi_rdy), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .rx_err(rx_err)
   );

   always @(posedge clk) if (rst_n && rx_err) err_cnt <= err_cnt + 1;

   typedef struct packed {
      logic [7:0]  hdr;
      logic [31:0] word;
      logic        ok;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{8'h80, 32'hDEADBEEF, 1'b1},
      '{8'h80, 32'h00000001, 1'b1},
      '{8'h81, 32'h12345678, 1'b0},
      '{8'h00, 32'hCAFEF00D, 1'b0},
      '{8'h80, 32'h80000000, 1'b1},
      '{8'hC0, 32'h0F0F0F0F, 1'b0},
      '{8'h80, 32'hA5C3E187, 1'b1},
      '{8'h01, 32'h11111111, 1'b0}
   };

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic spi_bit(input logic b);
      mosi = b; tick(H);
      sclk = 1'b1; tick(H);
      sclk = 1'b0;
   endtask

   task automatic spi_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) spi_bit(b[i]);
   endtask

   task automatic spi_word(input logic [31:0] w);
      for (int i = 3; i >= 0; i--) spi_byte(w[i*8 +: 8]);
   endtask

   task automatic cs_lo(); cs_n = 1'b0; tick(H); endtask
   task automatic cs_hi(); tick(H); cs_n = 1'b1; tick(10); endtask

   task automatic accept();
      out_ready = 1'b1; tick(1); out_ready = 1'b0; tick(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int e0;
      tick(3);
      rst_n = 1'b1;
      tick(4);
      // R1 reset state
      chk("R1 rdy", 32'(spi_rdy), 32'd1);
      chk("R1 valid", 32'(out_valid), 32'd0);
      chk("R1 err", 32'(err_cnt), 32'd0);

      // R2 R3 R4: table walk
      foreach (VECS[k]) begin
         e0 = err_cnt;
         cs_lo(); spi_byte(VECS[k].hdr); spi_word(VECS[k].word); tick(12);
         chk("R2/R4 valid", 32'(out_valid), 32'(VECS[k].ok));
         chk("R5 rdy", 32'(spi_rdy), 32'(!VECS[k].ok));
         if (VECS[k].ok) chk("R3 data", out_data, VECS[k].word);
         cs_hi();
         chk("R4 no err", 32'(err_cnt - e0), 32'd0);
         accept();
         chk("R5 released", 32'({out_valid, spi_rdy}), 32'b01);
      end

      // R6 two words in one transaction with polling
      cs_lo(); spi_byte(8'h80); spi_word(32'h01234567); tick(12);
      chk("R6 word1", out_data, 32'h01234567);
      tick(20);
      chk("R5 held", 32'({out_valid, spi_rdy}), 32'b10);
      chk("R5 stable", out_data, 32'h01234567);
      accept();
      while (!spi_rdy) tick(1);
      spi_word(32'h89ABCDEF); tick(12);
      chk("R6 word2", out_data, 32'h89ABCDEF);
      chk("R6 valid2", 32'(out_valid), 32'd1);
      cs_hi(); accept();

      // R7 abort after two bytes
      e0 = err_cnt;
      cs_lo(); spi_byte(8'h80); spi_byte(8'hAA); spi_byte(8'h55); cs_hi();
      chk("R7 err bytes", 32'(err_cnt - e0), 32'd1);
      chk("R7 no valid", 32'(out_valid), 32'd0);

      // R7 abort after three bits
      e0 = err_cnt;
      cs_lo(); spi_byte(8'h80); spi_bit(1'b1); spi_bit(1'b0); spi_bit(1'b1); cs_hi();
      chk("R7 err bits", 32'(err_cnt - e0), 32'd1);

      // R9 fresh transaction after abort decodes cleanly
      cs_lo(); spi_byte(8'h80); spi_word(32'h5A5A0001); tick(12);
      chk("R9 valid", 32'(out_valid), 32'd1);
      chk("R9 data", out_data, 32'h5A5A0001);
      cs_hi(); accept();

      // R7 boundary: rise on word boundary gives no pulse
      e0 = err_cnt;
      cs_lo(); spi_byte(8'h80); cs_hi();
      chk("R7 boundary", 32'(err_cnt - e0), 32'd0);

      // R4 abort inside ignored transaction
      e0 = err_cnt;
      cs_lo(); spi_byte(8'h81); spi_byte(8'hFF); spi_bit(1'b1); cs_hi();
      chk("R4 skip abort", 32'(err_cnt - e0), 32'd0);
      chk("R4 skip valid", 32'(out_valid), 32'd0);

      // R8 overrun while a word is held
      e0 = err_cnt;
      cs_lo(); spi_byte(8'h80); spi_word(32'hFEEDFACE); spi_word(32'h0BADC0DE); tick(12);
      chk("R8 err", 32'(err_cnt - e0), 32'd1);
      chk("R8 held data", out_data, 32'hFEEDFACE);
      chk("R8 valid", 32'(out_valid), 32'd1);
      cs_hi(); accept();
      chk("R8 drained", 32'(out_valid), 32'd0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule